// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a binary up-counter with a parallel preset path. On each rising clock edge it does one of three things. It can take a new value from the preset bus, step up by one, or keep its value. Two separate enables gate the stepping. The second enable also gates a terminal-count flag, so a row of these counters can be chained: one counter's flag drives the next counter's enables.

Reset is active low and always returns the count to zero. A build-time parameter decides how reset acts. In one form it clears the register at once, with no clock edge. In the other form it is sampled on the rising edge like any other control. Every control pin is a plain level signal. There is no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `presettable_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0. This wins over loading and over counting.
- R2: With `ASYNC_RST=1`, a low `rst_n` clears the count at once, with no wait for a clock edge.
- R3: With `ASYNC_RST=0`, a low `rst_n` leaves the count alone until the next rising edge, and the count becomes 0 at that edge.
- R4: When `load_n` is low at a rising edge and reset is inactive, `count` takes the value of `din`, whatever the enables are. Bit 0 of both buses is the least significant bit.
- R5: When `load_n`, `en_p` and `en_t` are all high at a rising edge, the count goes up by one. It runs in binary from 0 to 15 and then wraps to 0.
- R6: When `load_n` is high and either enable is low, the count holds its value across the edge.
- R7: `carry` is high while `en_t` is high and every count bit is 1. It is combinational from the current count, so it follows `en_t` within the same cycle.
- R8: A low `en_t` forces `carry` low. A low `en_p` alone leaves `carry` showing the all-ones condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; timing chosen by `ASYNC_RST` |
| load_n | input | 1 | Active-low synchronous preset strobe |
| din | input | WIDTH | Preset value, bit 0 least significant |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| count | output | WIDTH | Registered count value |
| carry | output | 1 | Terminal-count flag for chaining |

## Verification
The bench drives one instance of each reset form with the same inputs. It drops reset in the middle of a cycle. The asynchronous copy must read zero at once, while the synchronous copy must keep its value until the edge. A design that mixed up the two forms would fail one side of that check. The bench also asserts load with both enables low, and loads while the count is at its maximum. A design that gated loading with the enables, or let counting win over loading, would show the wrong value after those edges. It runs a full lap past 15 to catch a missing wrap. Finally it holds at the all-ones value with each enable low in turn. A carry that ignored `en_t`, or that wrongly depended on `en_p`, would show up there.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import ctr_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output ctr_op_e op
);
  // Preset wins over counting; counting needs both enables.
  always_comb begin
    if (!load_n)          op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                  op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_state.sv
module ctr_state
  import ctr_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = q + ONE;
      default:  nxt = q;
    endcase
  end

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ZERO;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) q <= ZERO;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             en_t,
  input  logic [WIDTH-1:0] q,
  output logic             carry
);
  localparam logic [WIDTH-1:0] FULL = '1;

  assign carry = en_t && (q == FULL);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import ctr_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  ctr_op_e op;

  ctr_ctrl u_ctrl (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  ctr_state #(.WIDTH(WIDTH), .ASYNC_RST(ASYNC_RST)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .din   (din),
    .q     (count)
  );

  ctr_carry #(.WIDTH(WIDTH)) u_carry (
    .en_t  (en_t),
    .q     (count),
    .carry (carry)
  );
endmodule

// File: rtl/ctr_chk.sv
module ctr_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] count,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (count == '0));

  a_r4_load_takes_din: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (count == $past(din)));

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_p && en_t) |=> (count == $past(count) + ONE));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_p && en_t)) |=> $stable(count));

  a_r7_carry_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (en_t && (&count)) |-> carry);

  a_r8_carry_needs_t: assert property (@(posedge clk) disable iff (!rst_n)
    !en_t |-> !carry);
endmodule

bind presettable_counter ctr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load_n (load_n),
  .din    (din),
  .en_p   (en_p),
  .en_t   (en_t),
  .count  (count),
  .carry  (carry)
);

// File: tb/test_presettable_counter.sv
module test_presettable_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] din = '0;
  logic         en_p = 1'b1;
  logic         en_t = 1'b1;
  logic [W-1:0] cnt_a, cnt_s;
  logic         cy_a, cy_s;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  presettable_counter #(.WIDTH(W), .ASYNC_RST(1'b1)) i_presettable_counter (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .count(cnt_a), .carry(cy_a));

  presettable_counter #(.WIDTH(W), .ASYNC_RST(1'b0)) i_presettable_counter_s (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .count(cnt_s), .carry(cy_s));

  // {load_n, en_p, en_t, din[3:0], exp_count[3:0], exp_carry}
  localparam logic [11:0] VEC [0:11] = '{
    12'b0_1_1_1010_1010_0,  // R4 load
    12'b1_1_1_0000_1011_0,  // R5 count
    12'b1_1_1_0000_1100_0,  // R5 count
    12'b0_0_0_1110_1110_0,  // R4 load with enables low
    12'b1_1_1_0000_1111_1,  // R5/R7 reach max
    12'b1_0_1_0000_1111_1,  // R6/R8 en_p low, carry stays
    12'b1_1_0_0000_1111_0,  // R6/R8 en_t low, carry drops
    12'b1_1_1_0000_0000_0,  // R5 wrap
    12'b0_0_1_1111_1111_1,  // R4/R7 load max
    12'b0_1_1_0011_0011_0,  // R4 load beats count
    12'b1_0_0_0101_0011_0,  // R6 hold
    12'b1_1_1_0000_0100_0   // R5 count
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Reset state (R1)
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset count async", cnt_a, 0);
    check("R1 reset count sync", cnt_s, 0);
    check("R7 carry at zero", cy_a, 0);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {load_n, en_p, en_t, din} = VEC[i][11:5];
      @(posedge clk);
      #5;
      check($sformatf("R4/R5/R6 vec %0d count async", i), cnt_a, VEC[i][4:1]);
      check($sformatf("R4/R5/R6 vec %0d count sync", i), cnt_s, VEC[i][4:1]);
      check($sformatf("R7/R8 vec %0d carry async", i), cy_a, VEC[i][0]);
      check($sformatf("R7/R8 vec %0d carry sync", i), cy_s, VEC[i][0]);
    end

    // Carry follows en_t inside the cycle (R7, R8)
    @(negedge clk);
    load_n = 1'b0; din = 4'hF; en_p = 1'b1; en_t = 1'b1;
    @(posedge clk); #5;
    load_n = 1'b1; en_p = 1'b0;
    #1 check("R7 carry comb high", cy_a, 1);
    en_t = 1'b0;
    #1 check("R8 carry forced low", cy_a, 0);
    en_t = 1'b1;
    #1 check("R7 carry back high", cy_s, 1);

    // Mid-cycle reset: async clears at once, sync waits (R2, R3)
    @(negedge clk);
    load_n = 1'b0; din = 4'h9; en_p = 1'b0; en_t = 1'b0;
    @(posedge clk); #5;
    load_n = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R2 async clears without edge", cnt_a, 0);
    check("R3 sync keeps value before edge", cnt_s, 9);
    @(posedge clk); #5;
    check("R3 sync clears at edge", cnt_s, 0);

    // Reset beats load (R1)
    @(negedge clk);
    load_n = 1'b0; din = 4'h7; en_p = 1'b1; en_t = 1'b1;
    @(posedge clk); #5;
    check("R1 reset over load async", cnt_a, 0);
    check("R1 reset over load sync", cnt_s, 0);
    @(negedge clk);
    rst_n = 1'b1; load_n = 1'b1;

    // Full lap with wrap (R5, R7)
    for (int k = 1; k <= 17; k++) begin
      @(posedge clk); #5;
      check($sformatf("R5 lap step %0d async", k), cnt_a, k % 16);
      check($sformatf("R5 lap step %0d sync", k), cnt_s, k % 16);
      check($sformatf("R7 lap carry %0d", k), cy_a, (k % 16) == 15 ? 1 : 0);
    end

    finish_run();
  end
endmodule